// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset Steering

The block counts down a programmable number of periodic tick strobes and raises an event when the count runs out. The tick is expected to arrive at 1/16-second intervals. A byte-wide control register sets the timeout. Its two low bits pick a resolution that is a power of four: 1/16 s, 1/4 s, 1 s or 4 s. A five-bit multiplier scales that resolution. Software restarts the countdown by writing the control register. It can also restart it by reading the control register, which reloads the value already stored.

When the countdown expires, the block sets a sticky timeout flag. The top bit of the control register then chooses what happens next. If that bit is set, the block issues a one-cycle system reset request, clears the control register and clears the century-enable bit in a companion calendar byte. If that bit is clear, the block issues a one-cycle interrupt pulse and leaves the control register unchanged. In both cases the countdown stops until software restarts it.

The register port has a two-bit address and separate read and write strobes. Read data is combinational.

| Address | Register | Use |
|---------|----------|-----|
| 0 | control | Read and write. Holds the steering bit, multiplier and resolution. |
| 1 | flags | Read only. Holds the timeout flag. |
| 2 | calendar | Holds only the century-enable bit. |
| 3 | none | Reads as zero. |

Top module: `wdt_top`

## Requirements
- R1: The control register holds the resolution in bits [1:0] and the multiplier in bits [6:2]. After a restart, the timeout fires on the N-th tick, where N = (1 << 2*resolution) * multiplier. The event output goes high in the cycle after the edge that samples that tick.
- R2: A control value of zero never produces an event. Neither does any value whose multiplier field is zero.
- R3: A write to address 0 stores the whole byte, restarts the countdown with the new value and clears the timeout flag.
- R4: A read of address 0 returns the stored byte. It also restarts the countdown with the stored value and clears the timeout flag.
- R5: An expiry sets the timeout flag. The flag appears on the flag output and as bit 7 of address 1, with the other bits of address 1 reading 0. The flag stays set until the next restart.
- R6: If control bit 7 is 1 at expiry, the reset request goes high for exactly one cycle. In the same cycle the control register becomes 0x00 and the century-enable bit becomes 0.
- R7: If control bit 7 is 0 at expiry, the interrupt goes high for exactly one cycle and the control register keeps its value.
- R8: After an expiry, further ticks produce no further event until the next restart.
- R9: Writes to address 1 have no effect. Address 2 stores only bit 6 of the written byte and reads back as that bit with all other bits 0. Address 3 reads as 0x00.
- R10: A restart in the same cycle as the tick that would expire the count takes priority. No event occurs, and the countdown starts afresh.
- R11: After reset the control register, flag, century-enable bit and both event outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe every 1/16 s |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 restarts the countdown) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle interrupt pulse |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
Random control bytes are used to exercise the timeout length. They cover every resolution, multipliers from 1 to 31 and both settings of the steering bit. For each byte the bench checks that nothing fires on the tick before the expected count and that the event fires on the expected tick. This catches errors in the exponent and in the multiplier separately.

Directed cases probe the boundaries. A zero byte and a zero multiplier with a nonzero resolution check the disabled cases. A read-only restart part way through the count checks that a read reloads the timer. A restart that lands on the same cycle as the expiring tick checks the priority rule. Repeated ticks after an expiry check that the countdown stays stopped. The side effects on the flag, control and calendar registers are read back after each steering choice to separate the reset path from the interrupt path.

// File: rtl/wdt_pkg.sv
// Package: shared widths, register addresses and the timeout calculation.
// Assumes the resolution field selects a power of four of the base tick.
package wdt_pkg;
    localparam int DATA_W  = 8;
    localparam int RES_W   = 2;
    localparam int MULT_W  = 5;
    localparam int ADDR_W  = 2;
    // Largest shift is 2*(2^RES_W - 1); the count must hold mult << that.
    localparam int SHIFT_MAX = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W   = MULT_W + SHIFT_MAX;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_FLAGS = 2'd1,
        REG_CAL   = 2'd2,
        REG_NONE  = 2'd3
    } wdt_addr_e;

    // Number of ticks until expiry for a control byte; zero means disabled.
    function automatic logic [CNT_W-1:0] ticks_for(input logic [DATA_W-1:0] v);
        logic [CNT_W-1:0] m;
        m = CNT_W'(v[RES_W+MULT_W-1:RES_W]);
        return m << (2 * v[RES_W-1:0]);
    endfunction
endpackage

// File: rtl/wdt_regfile.sv
// Register file: control byte, sticky flag and the century-enable bit.
// Detects restarts (write or read of the control address) and applies
// the side effects of an expiry. Assumes expire never coincides with a
// restart (the countdown enforces that).
module wdt_regfile
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              expire,
    output logic              kick,
    output logic [DATA_W-1:0] kick_val,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              cen_q,
    output logic              flag_q
);
    logic ctrl_hit;

    // Decode restart and pick the value to load (write data wins over read).
    always_comb begin
        ctrl_hit = (reg_addr == REG_CTRL);
        kick     = ctrl_hit && (reg_wr || reg_rd);
        kick_val = reg_wr ? reg_wdata : ctrl_q;
    end

    // Control byte: written by software, zeroed by a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && ctrl_hit)
            ctrl_q <= reg_wdata;
        else if (expire && ctrl_q[DATA_W-1])
            ctrl_q <= '0;
    end

    // Century-enable bit: bit 6 of the calendar byte, cleared by reset steering.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cen_q <= 1'b0;
        else if (reg_wr && reg_addr == REG_CAL)
            cen_q <= reg_wdata[6];
        else if (expire && ctrl_q[DATA_W-1])
            cen_q <= 1'b0;
    end

    // Sticky timeout flag: set on expiry, cleared by any restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (kick)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
    end

    // Read data multiplexer.
    always_comb begin
        unique case (wdt_addr_e'(reg_addr))
            REG_CTRL:  reg_rdata = ctrl_q;
            REG_FLAGS: reg_rdata = {flag_q, {(DATA_W-1){1'b0}}};
            REG_CAL:   reg_rdata = {1'b0, cen_q, {(DATA_W-2){1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end

    assert_flag_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !flag_q);
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !kick) |=> flag_q);
endmodule

// File: rtl/wdt_countdown.sv
// Tick countdown. A restart loads the tick count for the given control
// byte and arms the counter when that count is nonzero. expire is high
// for the cycle in which the last tick is sampled. A restart in that
// cycle wins. The counter disarms after expiry.
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              expire,
    output logic              armed_q
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_cnt;

    // Expiry detect and load count.
    always_comb begin
        load_cnt = ticks_for(load_val);
        expire   = armed_q && tick && !load && (count_q == CNT_W'(1));
    end

    // Counter and arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            count_q <= load_cnt;
            armed_q <= (load_cnt != '0);
        end else if (expire) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (armed_q && tick) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assert_armed_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> count_q != '0);
    assert_stop_after_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !armed_q);
endmodule

// File: rtl/wdt_event.sv
// Expiry steering: turns the expiry strobe into a registered one-cycle
// reset request or interrupt according to the steering bit.
module wdt_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer_rst,
    output logic rst_req_q,
    output logic irq_q
);
    // Register the steered event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            rst_req_q <= expire && steer_rst;
            irq_q     <= expire && !steer_rst;
        end
    end

    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> !rst_req_q);
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_q && irq_q));
endmodule

// File: rtl/wdt_top.sv
// Watchdog top: register file, tick countdown and event steering.
// Assumes tick is a one-cycle strobe synchronous to clk.
module wdt_top
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst_req,
    output logic              wd_irq,
    output logic              wd_flag
);
    logic              expire;
    logic              kick;
    logic [DATA_W-1:0] kick_val;
    logic [DATA_W-1:0] ctrl_q;
    logic              cen_q;
    logic              armed_q;

    wdt_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .expire(expire), .kick(kick), .kick_val(kick_val),
        .ctrl_q(ctrl_q), .cen_q(cen_q), .flag_q(wd_flag)
    );

    wdt_countdown u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(kick),
        .load_val(kick_val), .expire(expire), .armed_q(armed_q)
    );

    wdt_event u_evt (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .steer_rst(ctrl_q[DATA_W-1]), .rst_req_q(sys_rst_req), .irq_q(wd_irq)
    );

    assert_rst_side_effects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (ctrl_q == '0) && !cen_q && !armed_q);
    assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req || wd_irq) |-> wd_flag);
    assert_irq_keeps_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> ctrl_q == $past(ctrl_q));
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst_req, wd_irq, wd_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rst   = 0;
    int n_irq   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst_req(sys_rst_req), .wd_irq(wd_irq), .wd_flag(wd_flag)
    );

    // Event counters seen at clock edges.
    always @(posedge clk) begin
        if (sys_rst_req) n_rst++;
        if (wd_irq) n_irq++;
    end

    function automatic int exp_ticks(input logic [7:0] v);
        return (1 << (2 * v[1:0])) * int'(v[6:2]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // One full timeout with the checks for both steering choices.
    task automatic run_timeout(input logic [7:0] v);
        int n, r0, i0;
        logic [7:0] d;
        n = exp_ticks(v);
        wr(2'd2, 8'hFF);
        wr(2'd0, v);
        r0 = n_rst; i0 = n_irq;
        ticks(n - 1);
        chk("R1 early", (n_rst - r0) + (n_irq - i0), 0);
        ticks(1);
        chk(v[7] ? "R6 reset pulse" : "R7 irq pulse", v[7] ? sys_rst_req : wd_irq, 1);
        @(negedge clk);
        chk("R1 count", v[7] ? n_rst - r0 : n_irq - i0, 1);
        chk("R6/R7 other", v[7] ? n_irq - i0 : n_rst - r0, 0);
        chk("R5 flag out", wd_flag, 1);
        rd(2'd1, d); chk("R5 flags reg", d, 8'h80);
        ticks(3);
        chk("R8 no repeat", (n_rst - r0) + (n_irq - i0), 1);
        rd(2'd2, d); chk("R6 century", d, v[7] ? 8'h00 : 8'h40);
        rd(2'd0, d); chk("R6/R7 ctrl", d, v[7] ? 8'h00 : v);
        chk("R4 read clears flag", wd_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int r0, i0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rst_req", sys_rst_req, 0);
        chk("R11 irq", wd_irq, 0);
        chk("R11 flag", wd_flag, 0);
        rd(2'd0, d); chk("R11 ctrl", d, 0);
        rd(2'd2, d); chk("R11 century", d, 0);
        rd(2'd3, d); chk("R9 addr3", d, 0);

        // R2 disabled cases
        r0 = n_rst; i0 = n_irq;
        wr(2'd0, 8'h00); ticks(80);
        wr(2'd0, 8'h83); ticks(80);
        chk("R2 disabled", (n_rst - r0) + (n_irq - i0), 0);

        // R9 calendar keeps bit 6 only
        wr(2'd2, 8'hBF); rd(2'd2, d); chk("R9 cal bit6 only", d, 8'h00);
        wr(2'd2, 8'h40); rd(2'd2, d); chk("R9 cal set", d, 8'h40);

        // Directed timeouts on both steering paths
        run_timeout(8'h04);
        run_timeout(8'h85);

        // R4 read restarts: 4-tick timeout, read after 3 ticks
        r0 = n_rst; i0 = n_irq;
        wr(2'd0, 8'h05);
        ticks(3); rd(2'd0, d); chk("R4 read data", d, 8'h05);
        ticks(3);
        chk("R4 restart by read", n_irq - i0, 0);
        ticks(1);
        @(negedge clk);
        chk("R4 fires after reload", n_irq - i0, 1);

        // R3 write clears flag; R9 write to flags ignored
        chk("R5 flag set", wd_flag, 1);
        wr(2'd1, 8'h00);
        chk("R9 flags write ignored", wd_flag, 1);
        wr(2'd0, 8'h00);
        chk("R3 write clears flag", wd_flag, 0);

        // R10 restart beats the expiring tick
        r0 = n_rst; i0 = n_irq;
        wr(2'd0, 8'h84);
        @(negedge clk);
        tick = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h84; reg_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        chk("R10 restart wins", (n_rst - r0) + (n_irq - i0), 0);
        ticks(1);
        @(negedge clk);
        chk("R10 fires after restart", n_rst - r0, 1);

        // Random control bytes
        for (int k = 0; k < 12; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (v[6:2] == 5'd0) v[2] = 1'b1;
            if (v[1:0] == 2'd3) v[6:2] = 5'(1 + ($urandom % 8));
            run_timeout(v);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule